// File: doc/BRIEF.md
# Serial-Bus Panel Bias Code Controller

This block is a two-wire serial-bus target that owns a 7-bit code used to set the sink current of a display bias generator. The code lives in a working register that drives the current setting directly. A second, retained copy models non-volatile storage. A bus host can read the working code, load it, or commit a new value to the retained copy. On every reset the working register is reloaded from the retained copy.

Each transfer carries one data byte after the address byte. Bits 7 to 1 of a write byte hold the code. Bit 0 selects where the code goes: the working register or the retained copy. While a retained-copy commit is in progress, a busy timer runs for a fixed number of clock cycles. During that time the target refuses write transfers. A write-allow input gates every update.

Bus lines are sampled on the system clock through two-flop synchronizers. The target answers on the data line through an open-drain output enable, where 1 means pull the line low.

Top module: `vcom_code_ctrl`

## Requirements
- R1: The target acknowledges only the 7-bit address 7'b1001111. It sends the address MSB first and follows it with a direction bit (1 read, 0 write). Any other address gets no acknowledge and changes nothing.
- R2: A Start is data falling while the clock is high. A Stop is data rising while the clock is high. A Stop at any point returns the target to idle with the data line released. A Start at any point, including a repeated Start, begins a new address byte.
- R3: Bytes are 8 bits, MSB first, sampled on clock rising edges. The receiver acknowledges by pulling data low for the ninth clock. The target only begins driving data low after a clock falling edge.
- R4: In a write data byte, bits 7..1 carry the code and bit 0 is a selector. With the selector at 1, the working register takes the code when the data byte is acknowledged. The `dac_code_o` port shows it before the Stop.
- R5: With the selector at 0, the code is committed to the retained copy and the working register keeps its value. The committed code appears on `dac_code_o` after the next reset.
- R6: A retained-copy commit raises `nv_busy_o` for exactly BUSY_CYCLES clock cycles. While busy, an address byte with the write direction is not acknowledged, and a read is still acknowledged and served.
- R7: A read returns the working code in bits 7..1 of the byte, MSB first. Bit 0 is left released, so it reads as 1. The host ends with a not-acknowledge and a Stop.
- R8: With `wr_allow_i` low, the address and data of a write are still acknowledged, but neither the working register nor the retained copy changes, and no busy period starts.
- R9: Reset loads the working register from the retained copy. The factory value of the retained copy is byte 80h, which is code 64.
- R10: Every code from 0 to 127 can be written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; reloads the working code |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wr_allow_i | input | 1 | High permits updates of the working code and retained copy |
| sda_oe_o | output | 1 | 1 pulls the bus data line low |
| dac_code_o | output | 7 | Working code driving the current setting |
| nv_busy_o | output | 1 | High while a retained-copy commit is in progress |

## Verification
A wrong bit count or a wrong shift order shows up at once in the next acknowledge slot, or in the bits a read sends back, within the same byte time. A wrong selector decode or a missing write-allow gate shows up on `dac_code_o` straight after the data acknowledge. For the retained copy, it shows up only after the next reset, so the bench resets on purpose to expose it. A busy timer of the wrong length is visible as the count of cycles `nv_busy_o` stays high, and as whether a write address is acknowledged inside that window.

// File: rtl/vcom_ctrl_pkg.sv
package vcom_ctrl_pkg;

  // transfer sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_DONE
  } xfer_state_t;

  // bus conditions seen on the synchronized lines
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;

endmodule

// File: rtl/bus_events.sv
module bus_events
  import vcom_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);

  logic scl_p;
  logic sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    evt.rise  = !scl_p && scl_s;
    evt.fall  = scl_p && !scl_s;
    evt.start = scl_p && scl_s && sda_p && !sda_s;
    evt.stop  = scl_p && scl_s && !sda_p && sda_s;
  end

endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import vcom_ctrl_pkg::*;
#(
  parameter int         CODE_W = 7,
  parameter logic [6:0] ADDR7  = 7'b1001111,
  localparam int        BYTE_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic              sda_s,
  input  logic              busy_i,
  input  logic [CODE_W-1:0] rd_code_i,
  output logic              sda_oe_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] commit_byte_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  xfer_state_t       state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_read;
  logic              oe_q;
  logic              commit_q;
  logic              addr_hit;

  assign addr_hit = (shreg[BYTE_W-1:1] == ADDR7);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      is_read  <= 1'b0;
      oe_q     <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (evt.start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (evt.stop) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (evt.rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (evt.fall && bit_cnt == LAST_BIT) begin
              if (addr_hit && (shreg[0] || !busy_i)) begin
                oe_q    <= 1'b1;
                is_read <= shreg[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (evt.fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                shreg <= {rd_code_i, 1'b1};
                oe_q  <= !rd_code_i[CODE_W-1];
                state <= ST_RDATA;
              end else begin
                oe_q  <= 1'b0;
                state <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (evt.rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (evt.fall && bit_cnt == LAST_BIT) begin
              oe_q     <= 1'b1;
              commit_q <= 1'b1;
              state    <= ST_WDATA_ACK;
            end
          end
          ST_WDATA_ACK: begin
            if (evt.fall) begin
              oe_q  <= 1'b0;
              state <= ST_DONE;
            end
          end
          ST_RDATA: begin
            if (evt.rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (evt.fall) begin
              if (bit_cnt == LAST_BIT) begin
                oe_q  <= 1'b0;
                state <= ST_RACK;
              end else begin
                shreg <= {shreg[BYTE_W-2:0], 1'b1};
                oe_q  <= !shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (evt.fall) state <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o      = oe_q;
  assign commit_o      = commit_q;
  assign commit_byte_o = shreg;

  logic fall_ev;
  assign fall_ev = evt.fall;

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(fall_ev)); // R3

  AST_NO_WRITE_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_ACK && !is_read) |-> !busy_i); // R6

endmodule

// File: rtl/code_store.sv
module code_store #(
  parameter int                CODE_W      = 7,
  parameter logic [CODE_W-1:0] NV_DEFAULT  = 7'h40,
  parameter int                BUSY_CYCLES = 5_000_000,
  localparam int               BYTE_W      = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] commit_byte_i,
  input  logic              allow_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              busy_o
);

  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BCNT_W-1:0] BUSY_LOAD = BCNT_W'(BUSY_CYCLES);

  // retained copy: holds its contents across reset
  logic [CODE_W-1:0] nv_q = NV_DEFAULT;
  logic [CODE_W-1:0] dac_q;
  logic [BCNT_W-1:0] busy_cnt;
  logic              dac_go;
  logic              prog_go;

  assign dac_go  = commit_i && allow_i && commit_byte_i[0];
  assign prog_go = commit_i && allow_i && !commit_byte_i[0];

  always_ff @(posedge clk) begin
    if (prog_go) nv_q <= commit_byte_i[BYTE_W-1:1];
  end

  always_ff @(posedge clk) begin
    if (rst)         dac_q <= nv_q;
    else if (dac_go) dac_q <= commit_byte_i[BYTE_W-1:1];
  end

  always_ff @(posedge clk) begin
    if (rst)                busy_cnt <= '0;
    else if (prog_go)       busy_cnt <= BUSY_LOAD;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
  end

  assign dac_code_o = dac_q;
  assign busy_o     = (busy_cnt != '0);

  AST_DAC_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(dac_q)); // R4

  AST_WP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !allow_i) |=> ($stable(dac_q) && $stable(nv_q))); // R8

  AST_BUSY_FROM_PROG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(commit_i && !commit_byte_i[0])); // R6

  always_comb begin
    AST_BUSY_RANGE: assert (busy_cnt <= BUSY_LOAD); // R6
  end

endmodule

// File: rtl/vcom_code_ctrl.sv
module vcom_code_ctrl
  import vcom_ctrl_pkg::*;
#(
  parameter int                CODE_W      = 7,
  parameter logic [6:0]        ADDR7       = 7'b1001111,
  parameter logic [CODE_W-1:0] NV_DEFAULT  = 7'h40,
  parameter int                BUSY_CYCLES = 5_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_allow_i,
  output logic              sda_oe_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              nv_busy_o
);

  localparam int BYTE_W = CODE_W + 1;

  logic [2:0]        lines_s;
  bus_evt_t          evt;
  logic              commit;
  logic [BYTE_W-1:0] commit_byte;

  // bit 2: write-allow (reset low), bits 1..0: data and clock (idle high)
  line_sync #(.WIDTH(3), .RST_VAL(3'b011)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({wr_allow_i, sda_i, scl_i}),
    .dout (lines_s)
  );

  bus_events i_events (
    .clk   (clk),
    .rst   (rst),
    .scl_s (lines_s[0]),
    .sda_s (lines_s[1]),
    .evt   (evt)
  );

  xfer_fsm #(.CODE_W(CODE_W), .ADDR7(ADDR7)) i_fsm (
    .clk           (clk),
    .rst           (rst),
    .evt           (evt),
    .sda_s         (lines_s[1]),
    .busy_i        (nv_busy_o),
    .rd_code_i     (dac_code_o),
    .sda_oe_o      (sda_oe_o),
    .commit_o      (commit),
    .commit_byte_o (commit_byte)
  );

  code_store #(
    .CODE_W      (CODE_W),
    .NV_DEFAULT  (NV_DEFAULT),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) i_store (
    .clk           (clk),
    .rst           (rst),
    .commit_i      (commit),
    .commit_byte_i (commit_byte),
    .allow_i       (lines_s[2]),
    .dac_code_o    (dac_code_o),
    .busy_o        (nv_busy_o)
  );

endmodule

// File: tb/test_vcom_code_ctrl.sv
module test_vcom_code_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int BUSY       = 1000;
  localparam logic [6:0] OWN_ADDR = 7'b1001111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic allow = 1'b1;
  logic sda_oe;
  logic [6:0] code;
  logic busy;
  wire  sda_line = !(m_low || sda_oe);

  int checks = 0;
  int fails = 0;
  int busy_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  vcom_code_ctrl #(.BUSY_CYCLES(BUSY)) i_vcom_code_ctrl (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .wr_allow_i (allow),
    .sda_oe_o   (sda_oe),
    .dac_code_o (code),
    .nv_busy_o  (busy)
  );

  always @(negedge clk) if (busy) busy_seen++;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; scl = 1'b1; hold(Q);
    m_low = 1'b1; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    m_low = 1'b0; hold(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = !b; hold(Q);
    scl = 1'b1; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; hold(Q);
    scl = 1'b1; hold(Q/2);
    b = sda_line; hold(Q - Q/2);
    scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(nack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic host_nack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(host_nack);
  endtask

  task automatic write_xfer(input logic [6:0] a, input logic [7:0] d,
                            output logic an, output logic dn);
    bus_start();
    send_byte({a, 1'b0}, an);
    if (!an) send_byte(d, dn);
    else dn = 1'b1;
    bus_stop();
  endtask

  task automatic read_xfer(input logic [6:0] a, output logic an,
                           output logic [7:0] d);
    bus_start();
    send_byte({a, 1'b1}, an);
    if (!an) recv_byte(d, 1'b1);
    else d = 8'hFF;
    bus_stop();
  endtask

  task automatic pulse_reset();
    rst = 1'b1; hold(4);
    rst = 1'b0; hold(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic an, dn, nk;
    logic [7:0] rd;
    logic [6:0] keep;
    logic [6:0] bad [4] = '{7'h4E, 7'h0F, 7'h6F, 7'h4D};

    hold(4);
    rst = 1'b0;
    hold(4);

    // reset state: factory byte 80h gives code 64
    check(code == 7'd64, "R9", "reset code", code, 64);
    check(sda_oe == 1'b0, "R3", "reset data line released", sda_oe, 0);
    check(busy == 1'b0, "R6", "reset busy", busy, 0);

    // full code sweep: write working register then read it back
    for (int c = 0; c < 128; c++) begin
      write_xfer(OWN_ADDR, {7'(c), 1'b1}, an, dn);
      check(!an && !dn, "R3", "write acks", {an, dn}, 0);
      check(code == 7'(c), "R4", "working code after write", code, c);
      read_xfer(OWN_ADDR, an, rd);
      check(!an && rd == {7'(c), 1'b1}, "R10", "read back byte (R7)", rd, {c, 1'b1});
    end

    // wrong addresses are ignored
    keep = code;
    foreach (bad[i]) begin
      write_xfer(bad[i], {7'd5, 1'b1}, an, dn);
      check(an == 1'b1, "R1", "foreign address nack", an, 1);
      check(code == keep, "R1", "code unchanged", code, keep);
    end
    read_xfer(7'h4E, an, rd);
    check(an == 1'b1, "R1", "foreign read nack", an, 1);

    // stop in the middle of the address byte, then a normal write
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check(sda_oe == 1'b0 && code == keep, "R2", "abort by stop", code, keep);
    write_xfer(OWN_ADDR, {7'd77, 1'b1}, an, dn);
    check(!an && !dn && code == 7'd77, "R2", "write after abort", code, 77);

    // repeated start after the address ack restarts the transfer
    bus_start();
    send_byte({OWN_ADDR, 1'b0}, an);
    bus_start();
    send_byte({OWN_ADDR, 1'b0}, an);
    send_byte({7'd33, 1'b1}, dn);
    bus_stop();
    check(!an && !dn && code == 7'd33, "R2", "repeated start write", code, 33);

    // write-allow low: acks but nothing changes
    allow = 1'b0; hold(4);
    busy_seen = 0;
    write_xfer(OWN_ADDR, {7'd5, 1'b1}, an, dn);
    check(!an && !dn, "R8", "protected write still acked", {an, dn}, 0);
    check(code == 7'd33, "R8", "protected working code", code, 33);
    write_xfer(OWN_ADDR, {7'd9, 1'b0}, an, dn);
    check(busy_seen == 0, "R8", "no busy when protected", busy_seen, 0);
    pulse_reset();
    check(code == 7'd64, "R8", "retained copy untouched", code, 64);
    allow = 1'b1; hold(4);

    // program retained copy with 23
    write_xfer(OWN_ADDR, {7'd40, 1'b1}, an, dn);
    busy_seen = 0;
    write_xfer(OWN_ADDR, {7'd23, 1'b0}, an, dn);
    check(!an && !dn, "R5", "program write acked", {an, dn}, 0);
    check(code == 7'd40, "R5", "working code kept", code, 40);
    check(busy == 1'b1, "R6", "busy after program", busy, 1);
    read_xfer(OWN_ADDR, an, rd);
    check(!an && rd == {7'd40, 1'b1}, "R6", "read while busy", rd, 81);
    bus_start();
    send_byte({OWN_ADDR, 1'b0}, nk);
    bus_stop();
    check(nk == 1'b1, "R6", "write address nack while busy", nk, 1);
    hold(BUSY + 50);
    check(busy_seen == BUSY, "R6", "busy length", busy_seen, BUSY);
    check(busy == 1'b0, "R6", "busy ends", busy, 0);
    write_xfer(OWN_ADDR, {7'd41, 1'b1}, an, dn);
    check(!an && !dn && code == 7'd41, "R6", "write after busy", code, 41);

    pulse_reset();
    check(code == 7'd23, "R5", "reload programmed code (R9)", code, 23);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule